// File: doc/BRIEF.md
# Configurable I2S Transmitter

This block serialises 16-bit stereo PCM onto a three-wire audio link made of a bit clock, a word-select line and a data line. Each frame carries the left word and then the right word, most significant bit first, in 16 bit-clock periods per channel. A parallel sample pair is taken over a valid/ready handshake at the start of every frame. When no sample is offered, the frame goes out as zeros and a sticky underrun flag is raised.

A configuration write sets the mode and the clock divider. The mode word has three fields. One sets the word-select level that marks the left channel. One chooses between the delayed-MSB standard format and the left-justified format. One chooses whether the block drives the bit clock and word select itself or follows them from external pins. As master, the bit clock comes from the system clock through a programmable divider. As slave, the external clock and word select are brought in through two-flop synchronisers, and the block acts on their edges in the system clock domain.

Top module: `i2s_tx`

## Requirements
- R1: After reset, `sclk_o`, `ws_o`, `sd_o`, `in_ready_o` and `underrun_o` are all 0. The block comes up in slave mode.
- R2: When `cfg_we_i` is high and `cfg_ctrl_i` bits 4:0 and 6 are zero, the mode and the divider are loaded, the frame sequence restarts and `underrun_o` is cleared. A write with any of those reserved bits set is ignored entirely: no restart and no clearing of the flag.
- R3: With `cfg_ctrl_i` bit 8 = 1 (master), `sclk_o` toggles every `cfg_div_i` system clocks, so a full period is 2*div clocks. A divider of 0 counts as 1. With bit 8 = 0 (slave), `sclk_o` and `ws_o` stay 0.
- R4: With bit 5 = 0, the left word is sent while word select is low. With bit 5 = 1, the left word is sent while word select is high.
- R5: With bit 7 = 0 (standard format), the MSB of a word is on the data line at the second rising bit-clock edge after the word-select change. The LSB of the previous word is on the data line at the first rising edge after that change.
- R6: With bit 7 = 1 (left-justified), the MSB is on the data line at the first rising bit-clock edge after the word-select change.
- R7: A frame is 32 bit-clock periods long: 16 for the left channel, then 16 for the right. Each word goes out MSB first.
- R8: In master mode, `sd_o` and `ws_o` change only in the cycle in which `sclk_o` falls, except right after a configuration write.
- R9: `in_ready_o` is a one-cycle pulse in the cycle before the left slot begins. A sample is taken when `in_valid_i` is high in that cycle. In master mode, `sclk_o` falls on the next cycle.
- R10: If `in_valid_i` is low when `in_ready_o` pulses, the frame is sent as all zeros and `underrun_o` goes to 1. It stays at 1 until a valid configuration write.
- R11: In slave mode, the data line changes after each synchronised falling edge of `sclk_i`. A change of `ws_i` to the left level starts a new frame, and the sample is then sent in the selected format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ctrl_i | input | 9 | Mode word: bit 5 left-channel WS level, bit 7 left-justified, bit 8 master |
| cfg_div_i | input | DIV_W (8) | Bit-clock half period in system clocks (master mode) |
| in_valid_i | input | 1 | Stereo sample valid |
| in_ready_o | output | 1 | Sample taken this cycle (start of frame) |
| in_left_i | input | SAMPLE_W (16) | Left PCM word |
| in_right_i | input | SAMPLE_W (16) | Right PCM word |
| sclk_i | input | 1 | External bit clock (slave mode) |
| ws_i | input | 1 | External word select (slave mode) |
| sclk_o | output | 1 | Generated bit clock (master mode) |
| ws_o | output | 1 | Generated word select (master mode) |
| sd_o | output | 1 | Serial data, changes on falling bit clock |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
The master-mode table covers all four pairings of format and word-select polarity. It uses dividers of 0, 1, 2, 3 and 22 and sample pairs with distinct edge bits, such as 8001/7FFE and 0001/8000. A one-bit slip between the standard and left-justified formats corrupts the end bits of these words, a wrong polarity swaps the channels, and a wrong divider shows up in the measured bit-clock period. A slave run driven by an external clock model checks that frames follow the external word select through the synchronisers. Directed cases cover the zero-filled underrun frame, the sticky flag, and a write with reserved bits set, which must change nothing.

// File: rtl/i2s_tx_pkg.sv
`timescale 1ns/1ps
package i2s_tx_pkg;
  localparam int unsigned CTRL_W     = 9;
  localparam int unsigned BIT_WS_POL = 5;
  localparam int unsigned BIT_LJ     = 7;
  localparam int unsigned BIT_MASTER = 8;
  localparam logic [CTRL_W-1:0] CTRL_USED =
    (CTRL_W'(1) << BIT_WS_POL) | (CTRL_W'(1) << BIT_LJ) | (CTRL_W'(1) << BIT_MASTER);
  localparam logic [CTRL_W-1:0] CTRL_RSVD = ~CTRL_USED;

  typedef struct packed {
    logic master;
    logic lj;
    logic ws_left_hi;
  } i2s_mode_t;
endpackage

// File: rtl/i2s_tx_clkgen.sv
`timescale 1ns/1ps
module i2s_tx_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             master_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             sclk_ext_i,
  input  logic             ws_ext_i,
  output logic             sclk_o,
  output logic             ws_sync_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] div_cnt_q;
  logic [DIV_W-1:0] div_lim;
  logic             sclk_q;
  logic             toggle;
  logic [2:0]       sck_sync_q;
  logic [1:0]       ws_sync_q;

  assign div_lim = (div_i == '0) ? '0 : div_i - 1'b1;
  assign toggle  = master_i && (div_cnt_q == div_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt_q <= '0;
      sclk_q    <= 1'b0;
    end else if (restart_i || !master_i) begin
      div_cnt_q <= '0;
      sclk_q    <= 1'b0;
    end else if (toggle) begin
      div_cnt_q <= '0;
      sclk_q    <= ~sclk_q;
    end else begin
      div_cnt_q <= div_cnt_q + 1'b1;
    end
  end

  // two-flop synchronisers, third stage for edge detect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_sync_q <= '0;
      ws_sync_q  <= '0;
    end else begin
      sck_sync_q <= {sck_sync_q[1:0], sclk_ext_i};
      ws_sync_q  <= {ws_sync_q[0], ws_ext_i};
    end
  end

  assign sclk_o    = sclk_q;
  assign ws_sync_o = ws_sync_q[1];
  assign fall_o    = !restart_i &&
                     (master_i ? (toggle && sclk_q) : (sck_sync_q[2] && !sck_sync_q[1]));
endmodule

// File: rtl/i2s_tx_shifter.sv
`timescale 1ns/1ps
module i2s_tx_shifter #(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                restart_i,
  input  logic                fall_i,
  input  logic                master_i,
  input  logic                lj_i,
  input  logic                ext_right_i,
  input  logic                in_valid_i,
  input  logic [SAMPLE_W-1:0] in_left_i,
  input  logic [SAMPLE_W-1:0] in_right_i,
  output logic                sd_o,
  output logic                right_slot_o,
  output logic                load_o
);
  localparam int unsigned CNT_W   = $clog2(SAMPLE_W) + 1;
  localparam int unsigned FRAME_W = 2 * SAMPLE_W;

  logic [CNT_W-1:0]   cnt_q, cnt_nx;
  logic [FRAME_W-1:0] sh_q;
  logic               dly_q;

  always_comb begin
    if (master_i) begin
      cnt_nx = cnt_q + 1'b1;
    end else if (ext_right_i != cnt_q[CNT_W-1]) begin
      cnt_nx = {ext_right_i, {(CNT_W-1){1'b0}}};
    end else begin
      cnt_nx = {cnt_q[CNT_W-1], cnt_q[CNT_W-2:0] + 1'b1};
    end
  end

  assign load_o = fall_i && cnt_q[CNT_W-1] && !cnt_nx[CNT_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      sh_q  <= '0;
      dly_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '1;
      sh_q  <= '0;
      dly_q <= 1'b0;
    end else if (fall_i) begin
      cnt_q <= cnt_nx;
      dly_q <= sh_q[FRAME_W-1];
      if (load_o) sh_q <= in_valid_i ? {in_left_i, in_right_i} : '0;
      else        sh_q <= sh_q << 1;
    end
  end

  // standard format emits the bit one period late
  assign sd_o         = lj_i ? sh_q[FRAME_W-1] : dly_q;
  assign right_slot_o = cnt_q[CNT_W-1];
endmodule

// File: rtl/i2s_tx.sv
`timescale 1ns/1ps
module i2s_tx
  import i2s_tx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned DIV_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [CTRL_W-1:0]   cfg_ctrl_i,
  input  logic [DIV_W-1:0]    cfg_div_i,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [SAMPLE_W-1:0] in_left_i,
  input  logic [SAMPLE_W-1:0] in_right_i,
  input  logic                sclk_i,
  input  logic                ws_i,
  output logic                sclk_o,
  output logic                ws_o,
  output logic                sd_o,
  output logic                underrun_o
);
  i2s_mode_t        mode_q;
  logic [DIV_W-1:0] div_q;
  logic             cfg_ok;
  logic             sclk_gen, ws_sync, fall, right_slot, load;
  logic             underrun_q;

  assign cfg_ok = cfg_we_i && ((cfg_ctrl_i & CTRL_RSVD) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      div_q  <= '0;
    end else if (cfg_ok) begin
      mode_q.master     <= cfg_ctrl_i[BIT_MASTER];
      mode_q.lj         <= cfg_ctrl_i[BIT_LJ];
      mode_q.ws_left_hi <= cfg_ctrl_i[BIT_WS_POL];
      div_q             <= cfg_div_i;
    end
  end

  i2s_tx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (cfg_ok),
    .master_i   (mode_q.master),
    .div_i      (div_q),
    .sclk_ext_i (sclk_i),
    .ws_ext_i   (ws_i),
    .sclk_o     (sclk_gen),
    .ws_sync_o  (ws_sync),
    .fall_o     (fall)
  );

  i2s_tx_shifter #(.SAMPLE_W(SAMPLE_W)) u_shifter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .restart_i    (cfg_ok),
    .fall_i       (fall),
    .master_i     (mode_q.master),
    .lj_i         (mode_q.lj),
    .ext_right_i  (ws_sync ^ mode_q.ws_left_hi),
    .in_valid_i   (in_valid_i),
    .in_left_i    (in_left_i),
    .in_right_i   (in_right_i),
    .sd_o         (sd_o),
    .right_slot_o (right_slot),
    .load_o       (load)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  underrun_q <= 1'b0;
    else if (cfg_ok)              underrun_q <= 1'b0;
    else if (load && !in_valid_i) underrun_q <= 1'b1;
  end

  assign in_ready_o = load;
  assign underrun_o = underrun_q;
  assign sclk_o     = mode_q.master & sclk_gen;
  assign ws_o       = mode_q.master & (right_slot ^ mode_q.ws_left_hi);
endmodule

// File: rtl/i2s_tx_chk.sv
`timescale 1ns/1ps
module i2s_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_ok_i,
  input logic master_i,
  input logic in_valid_i,
  input logic in_ready_o,
  input logic sclk_o,
  input logic ws_o,
  input logic sd_o,
  input logic underrun_o
);
  AST_SD_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && !$past(cfg_ok_i) && !$stable(sd_o)) |-> $fell(sclk_o)); // R8
  AST_WS_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && !$past(cfg_ok_i) && !$stable(ws_o)) |-> $fell(sclk_o)); // R8
  AST_SLAVE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && !$past(cfg_ok_i)) |-> (!sclk_o && !ws_o)); // R3
  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |=> !in_ready_o); // R9
  AST_READY_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && in_ready_o && !cfg_ok_i) |=> $fell(sclk_o)); // R9
  AST_UNDERRUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && !in_valid_i && !cfg_ok_i) |=> underrun_o); // R10
  AST_UNDERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !cfg_ok_i) |=> underrun_o); // R10
endmodule

bind i2s_tx i2s_tx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_ok_i   (cfg_ok),
  .master_i   (mode_q.master),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .sclk_o     (sclk_o),
  .ws_o       (ws_o),
  .sd_o       (sd_o),
  .underrun_o (underrun_o)
);

// File: tb/i2s_tx_bench.sv
`timescale 1ns/1ps
module i2s_tx_bench;
  typedef struct packed {
    logic        lj;
    logic        pol;
    logic [7:0]  div;
    logic [15:0] l;
    logic [15:0] r;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'd2,  16'hA5C3, 16'h1234},
    '{1'b0, 1'b1, 8'd3,  16'h8001, 16'h7FFE},
    '{1'b1, 1'b0, 8'd2,  16'hF00F, 16'h0FF0},
    '{1'b1, 1'b1, 8'h16, 16'hDEAD, 16'hBEEF},
    '{1'b0, 1'b0, 8'd0,  16'hFFFF, 16'h0000},
    '{1'b1, 1'b0, 8'd1,  16'h0001, 16'h8000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [8:0] cfg_ctrl = '0;
  logic [7:0] cfg_div = '0;
  logic in_valid = 1'b0, in_ready;
  logic [15:0] in_left = '0, in_right = '0;
  logic sclk_in = 1'b0, ws_in = 1'b1;
  logic sclk_out, ws_out, sd, underrun;

  always #10 clk = ~clk;

  i2s_tx u_i2s_tx (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_ctrl_i(cfg_ctrl),
    .cfg_div_i(cfg_div), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_left_i(in_left), .in_right_i(in_right), .sclk_i(sclk_in), .ws_i(ws_in),
    .sclk_o(sclk_out), .ws_o(ws_out), .sd_o(sd), .underrun_o(underrun)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // bench-side link decoder
  logic b_lj = 1'b0, b_pol = 1'b0, b_master = 1'b0;
  int   exp_per = 0;
  logic sck_p = 1'b0, ws_at = 1'b1, sck_pm = 1'b0, ws_pm = 1'b0, sd_pm = 1'b0, we_p = 1'b0, rdy_p = 1'b0;
  int   pos = 0, cyc = 0, last_rise = -1, rises = -1;
  logic [15:0] acc = '0, rx_l = '0, rx_r = '0;
  int   n_l = 0, n_r = 0, per_err = 0, r7_err = 0, r8_err = 0, r9_err = 0;

  always @(negedge clk) begin
    logic sck, ws, prev_left;
    cyc++;
    sck = b_master ? sclk_out : sclk_in;
    ws  = b_master ? ws_out   : ws_in;
    if (b_master && !we_p) begin
      if ((ws_out !== ws_pm || sd !== sd_pm) && !(sck_pm && !sclk_out)) r8_err++;
    end
    if (rdy_p && b_master && ws_out !== b_pol) r9_err++;
    if (in_ready && rdy_p) r9_err++;
    if (in_ready) begin
      if (rises >= 0 && rises != 32) r7_err++;
      rises = 0;
    end
    if (sck && !sck_p) begin
      if (rises >= 0) rises++;
      if (b_master && last_rise >= 0 && (cyc - last_rise) != exp_per) per_err++;
      last_rise = cyc;
      prev_left = (ws_at == b_pol);
      if (ws !== ws_at) begin pos = 0; ws_at = ws; end
      else pos++;
      if (b_lj) begin
        acc = {acc[14:0], sd};
        if (pos == 15) begin
          if (ws == b_pol) begin rx_l = acc; n_l++; end
          else begin rx_r = acc; n_r++; end
        end
      end else if (pos == 0) begin
        if (prev_left) begin rx_l = {acc[14:0], sd}; n_l++; end
        else begin rx_r = {acc[14:0], sd}; n_r++; end
        acc = '0;
      end else begin
        acc = {acc[14:0], sd};
      end
    end
    sck_p = sck; sck_pm = sclk_out; ws_pm = ws_out; sd_pm = sd;
    we_p = cfg_we; rdy_p = in_ready;
  end

  task automatic apply_cfg(input logic master, input logic lj, input logic pol,
                           input logic [7:0] div, input logic [8:0] rsvd);
    @(posedge clk); #2;
    cfg_we = 1'b1;
    cfg_ctrl = ({8'd0, master} << 8) | ({8'd0, lj} << 7) | ({8'd0, pol} << 5) | rsvd;
    cfg_div = div;
    @(posedge clk); #2;
    cfg_we = 1'b0;
    if (rsvd == '0) begin
      b_master = master; b_lj = lj; b_pol = pol;
      exp_per = 2 * ((div == 0) ? 1 : int'(div));
      sck_p = master ? 1'b0 : sclk_in;
      ws_at = ~pol; pos = 0; acc = '0; n_l = 0; n_r = 0;
      last_rise = -1; rises = -1; per_err = 0; r7_err = 0;
    end
  endtask

  task automatic wait_right(input int n);
    while (n_r < n) @(posedge clk);
    #2;
  endtask

  logic ext_stop = 1'b0;

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sclk_out === 1'b0 && ws_out === 1'b0 && sd === 1'b0, "R1 lines", {29'd0, sclk_out, ws_out, sd}, 0);
    chk(underrun === 1'b0 && in_ready === 1'b0, "R1 flags", {30'd0, underrun, in_ready}, 0);
    repeat (40) @(negedge clk);
    chk(sclk_out === 1'b0, "R3 slave after reset", {31'd0, sclk_out}, 0);

    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1; in_left = VECS[i].l; in_right = VECS[i].r;
      apply_cfg(1'b1, VECS[i].lj, VECS[i].pol, VECS[i].div, '0);
      wait_right(3);
      chk(rx_l === VECS[i].l, "R4 left word/polarity", {16'd0, rx_l}, {16'd0, VECS[i].l});
      chk(rx_r === VECS[i].r, VECS[i].lj ? "R6 right word" : "R5 right word", {16'd0, rx_r}, {16'd0, VECS[i].r});
      chk(per_err == 0, "R3 sclk period", per_err, 0);
      chk(r7_err == 0, "R7 frame length", r7_err, 0);
    end

    // R10 underrun
    in_valid = 1'b0;
    apply_cfg(1'b1, 1'b1, 1'b0, 8'd1, '0);
    wait_right(2);
    chk(underrun === 1'b1, "R10 flag set", {31'd0, underrun}, 1);
    chk(rx_l === 16'h0 && rx_r === 16'h0, "R10 zero frame", {rx_l, rx_r}, 0);
    in_valid = 1'b1;
    repeat (200) @(posedge clk);
    #2 chk(underrun === 1'b1, "R10 sticky", {31'd0, underrun}, 1);
    // R2 reserved bits set: write ignored
    apply_cfg(1'b1, 1'b1, 1'b0, 8'd1, 9'h041);
    @(negedge clk);
    chk(underrun === 1'b1, "R2 reserved write ignored", {31'd0, underrun}, 1);
    apply_cfg(1'b1, 1'b1, 1'b0, 8'd1, '0);
    @(negedge clk);
    chk(underrun === 1'b0, "R2 write clears flag", {31'd0, underrun}, 0);

    // R11 slave with external clock model
    in_left = 16'hC3A5; in_right = 16'h5A3C;
    sclk_in = 1'b0; ws_in = 1'b1;
    apply_cfg(1'b0, 1'b1, 1'b0, 8'd4, '0);
    fork
      begin
        int bitn = 0;
        while (!ext_stop) begin
          repeat (8) @(posedge clk); #5 sclk_in = 1'b1;
          repeat (8) @(posedge clk); #5 sclk_in = 1'b0;
          bitn++;
          if (bitn == 16) begin ws_in = ~ws_in; bitn = 0; end
        end
      end
    join_none
    wait_right(3);
    ext_stop = 1'b1;
    chk(rx_l === 16'hC3A5, "R11 slave left", {16'd0, rx_l}, 32'hC3A5);
    chk(rx_r === 16'h5A3C, "R11 slave right", {16'd0, rx_r}, 32'h5A3C);
    chk(sclk_out === 1'b0 && ws_out === 1'b0, "R3 slave outputs low", {30'd0, sclk_out, ws_out}, 0);

    chk(r8_err == 0, "R8 edges only on falling sclk", r8_err, 0);
    chk(r9_err == 0, "R9 ready timing", r9_err, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule